// File: doc/BRIEF.md
# Complementary Output Stage with Break

This block turns one reference waveform into a pair of complementary pin drives, a main output and a complementary output. Each pin has a data bit and an output-enable, and an enable of 0 means high impedance. A set of control bits chooses the state of each pin: a main enable, a run-mode off-state select, an idle-mode off-state select, a per-pin enable, a per-pin polarity and a per-pin idle level. When both pins are enabled in run mode, a programmable dead-time delays each pin's transition to its active level. During that gap neither transistor of a half bridge is on.

Two break inputs provide protection. While a break is asserted, both pins are forced to their inactive (polarity) levels by a combinational path that does not wait for a clock edge. Through its two-stage synchroniser, the break also clears the main enable. After the primary break, once one dead-time has passed on the running clock, the pins move to their programmed idle levels. The secondary break has no idle-level step, and it only acts when both off-state selects are 1. Software returns the block to run mode with a set request. That request is refused while either qualified break input is still high.

Top module: `cos_outstage`

## Requirements
- R1: With the main enable set and at most one pin enabled, an enabled pin is driven with (reference XOR its polarity bit). A disabled pin is driven at its polarity bit when run off-state select is 1. When that bit is 0, the disabled pin is undriven with data 0. This holds for both pins disabled as well.
- R2: With the main enable set and both pins enabled, the main pin is active while the reference is 1 and the complementary pin is active while it is 0. A pin's active level is its polarity bit inverted. Reference changes reach the pin that turns inactive 2 clock edges after being applied, and reach the pin that turns active dead_i + 2 edges after being applied.
- R3: If a reference pulse is shorter than the dead-time, the delayed pin stays inactive for the whole pulse.
- R4: With the main enable clear and no break active, both pins are undriven when idle off-state select is 0 or when both pin enables are 0. Otherwise both pins are driven at their inactive levels, which equal their polarity bits.
- R5: While a qualified break is asserted and the registered outputs still reflect run mode, each pin is forced without any clock edge. It is driven at its polarity bit if idle off-state select is 1 and at least one pin is enabled, and is undriven otherwise.
- R6: After a primary break reaches the clock domain and a further dead_i + 1 edges pass, the pins take their idle-level bits. A secondary break leaves them at their polarity bits.
- R7: The secondary break is ignored unless both run and idle off-state selects are 1.
- R8: A qualified break clears the main enable. A set request is ignored while any qualified break is high. An accepted set request re-enables the block and discards the idle-level state.
- R9: While the main enable was set on the previous edge and no break is high, the two pins are never both driven at their active levels.
- R10: Polarity and idle-level changes reach the pins on the next clock edge, because the pin data and enables are registered.
- R11: After reset the main enable is 0, and with the off-state selects at 0 both pins are undriven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_i | input | 1 | Reference waveform |
| dead_i | input | DT_W | Dead-time in clock cycles |
| off_run_i | input | 1 | Run-mode off-state select |
| off_idle_i | input | 1 | Idle-mode off-state select |
| en_p_i | input | 1 | Main pin enable |
| en_n_i | input | 1 | Complementary pin enable |
| pol_p_i | input | 1 | Main pin polarity (inactive level) |
| pol_n_i | input | 1 | Complementary pin polarity (inactive level) |
| idle_p_i | input | 1 | Main pin level after primary break |
| idle_n_i | input | 1 | Complementary pin level after primary break |
| brk_i | input | 1 | Primary break, active high, asynchronous |
| brk2_i | input | 1 | Secondary break, active high, asynchronous |
| men_set_i | input | 1 | Request to set the main enable |
| men_clr_i | input | 1 | Request to clear the main enable |
| out_p_o | output | 1 | Main pin data |
| oe_p_o | output | 1 | Main pin output-enable |
| out_n_o | output | 1 | Complementary pin data |
| oe_n_o | output | 1 | Complementary pin output-enable |
| main_en_o | output | 1 | Current main enable |

## Verification
The hardest state to reach is the window between a break arriving and the clock domain noticing it. In that window the pins are forced by the combinational override while the registers still hold run-mode values. The bench raises the break one nanosecond after a falling edge and samples the pins before the next rising edge. It then waits long enough to see the same pins settle first at their polarity levels and later at their idle levels. The non-overlap rule is checked by sweeping all 128 settings of the enable, off-state, pin-enable and polarity bits while the reference toggles with an irregular pattern.

// File: rtl/cos_pkg.sv
package cos_pkg;

  typedef struct packed {
    logic off_run;
    logic off_idle;
    logic en_p;
    logic en_n;
    logic pol_p;
    logic pol_n;
    logic idle_p;
    logic idle_n;
  } cos_ctrl_t;

  typedef struct packed {
    logic oe;
    logic dat;
  } cos_pin_t;

  // Pin value in run mode: enabled pins follow the level, disabled pins
  // either sit at their inactive level or are released.
  function automatic cos_pin_t run_pin(logic en, logic off_run, logic lvl, logic pol);
    cos_pin_t p;
    p.oe  = en | off_run;
    p.dat = en ? (lvl ^ pol) : (off_run & pol);
    return p;
  endfunction

  // Pin value with the main enable clear.
  function automatic cos_pin_t idle_pin(logic grant, logic use_idle, logic idle, logic pol);
    cos_pin_t p;
    p.oe  = grant;
    p.dat = grant & (use_idle ? idle : pol);
    return p;
  endfunction

endpackage

// File: rtl/cos_sync.sv
module cos_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/cos_deadtime.sv
module cos_deadtime #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ref_i,
  input  logic [DT_W-1:0] dead_i,
  output logic            ref_q_o,
  output logic            p_act_o,
  output logic            n_act_o
);

  localparam logic [DT_W-1:0] CNT_MAX = '1;

  logic            ref_q;
  logic [DT_W-1:0] since_edge;
  logic            settled;

  // since_edge counts cycles since the last reference change, saturating.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q      <= 1'b0;
      since_edge <= CNT_MAX;
    end else begin
      ref_q <= ref_i;
      if (ref_i != ref_q)            since_edge <= '0;
      else if (since_edge != CNT_MAX) since_edge <= since_edge + 1'b1;
    end
  end

  assign settled = (since_edge >= dead_i);
  assign ref_q_o = ref_q;
  assign p_act_o = ref_q & settled;
  assign n_act_o = ~ref_q & settled;

endmodule

// File: rtl/cos_break.sv
module cos_break #(
  parameter int DT_W        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            brk_i,
  input  logic            brk2_i,
  input  logic            off_run,
  input  logic            off_idle,
  input  logic            men_set,
  input  logic            men_clr,
  input  logic [DT_W-1:0] dead_i,
  output logic            main_en_o,
  output logic            idle_lvl_o,
  output logic            brk_raw_o
);

  logic [1:0]      bsync;
  logic            brk2_ok;
  logic            brk_eff;
  logic            b1_prev;
  logic            b1_rise;
  logic            set_ok;
  logic            men_q;
  logic            idle_q;
  logic            wait_q;
  logic [DT_W-1:0] wait_cnt;

  cos_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({brk2_i, brk_i}),
    .q     (bsync)
  );

  assign brk2_ok   = off_run & off_idle;
  assign brk_raw_o = brk_i | (brk2_i & brk2_ok);
  assign brk_eff   = bsync[0] | (bsync[1] & brk2_ok);
  assign b1_rise   = bsync[0] & ~b1_prev;
  assign set_ok    = men_set & ~brk_raw_o & ~brk_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b1_prev  <= 1'b0;
      men_q    <= 1'b0;
      idle_q   <= 1'b0;
      wait_q   <= 1'b0;
      wait_cnt <= '0;
    end else begin
      b1_prev <= bsync[0];

      if (brk_eff || men_clr) men_q <= 1'b0;
      else if (set_ok)        men_q <= 1'b1;

      // Second break step: one dead-time after the primary break.
      if (b1_rise) begin
        wait_q   <= 1'b1;
        wait_cnt <= '0;
      end else if (wait_q) begin
        if (wait_cnt >= dead_i) begin
          wait_q <= 1'b0;
          idle_q <= 1'b1;
        end else begin
          wait_cnt <= wait_cnt + 1'b1;
        end
      end

      if (set_ok) begin
        idle_q <= 1'b0;
        wait_q <= 1'b0;
      end
    end
  end

  assign main_en_o  = men_q;
  assign idle_lvl_o = idle_q;

endmodule

// File: rtl/cos_outsel.sv
module cos_outsel
  import cos_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  cos_ctrl_t ctrl,
  input  logic      main_en,
  input  logic      idle_lvl,
  input  logic      ref_q,
  input  logic      p_act,
  input  logic      n_act,
  output cos_pin_t  pin_p,
  output cos_pin_t  pin_n,
  output logic      run_q
);

  logic     both;
  logic     grant;
  cos_pin_t nxt_p;
  cos_pin_t nxt_n;

  assign both  = ctrl.en_p & ctrl.en_n;
  assign grant = ctrl.off_idle & (ctrl.en_p | ctrl.en_n);

  always_comb begin
    if (main_en) begin
      nxt_p = run_pin(ctrl.en_p, ctrl.off_run, both ? p_act : ref_q, ctrl.pol_p);
      nxt_n = run_pin(ctrl.en_n, ctrl.off_run, both ? n_act : ref_q, ctrl.pol_n);
    end else begin
      nxt_p = idle_pin(grant, idle_lvl, ctrl.idle_p, ctrl.pol_p);
      nxt_n = idle_pin(grant, idle_lvl, ctrl.idle_n, ctrl.pol_n);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_p <= '0;
      pin_n <= '0;
      run_q <= 1'b0;
    end else begin
      pin_p <= nxt_p;
      pin_n <= nxt_n;
      run_q <= main_en;
    end
  end

endmodule

// File: rtl/cos_outstage.sv
module cos_outstage
  import cos_pkg::*;
#(
  parameter int DT_W        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ref_i,
  input  logic [DT_W-1:0] dead_i,
  input  logic            off_run_i,
  input  logic            off_idle_i,
  input  logic            en_p_i,
  input  logic            en_n_i,
  input  logic            pol_p_i,
  input  logic            pol_n_i,
  input  logic            idle_p_i,
  input  logic            idle_n_i,
  input  logic            brk_i,
  input  logic            brk2_i,
  input  logic            men_set_i,
  input  logic            men_clr_i,
  output logic            out_p_o,
  output logic            oe_p_o,
  output logic            out_n_o,
  output logic            oe_n_o,
  output logic            main_en_o
);

  cos_ctrl_t ctrl;
  logic      ref_q, p_act, n_act;
  logic      main_en, idle_lvl, brk_raw;
  cos_pin_t  pin_p, pin_n;
  logic      run_q;
  logic      ovr, grant;

  assign ctrl = '{off_run: off_run_i, off_idle: off_idle_i, en_p: en_p_i, en_n: en_n_i,
                  pol_p: pol_p_i, pol_n: pol_n_i, idle_p: idle_p_i, idle_n: idle_n_i};

  cos_deadtime #(.DT_W(DT_W)) u_dt (
    .clk     (clk),
    .rst_n   (rst_n),
    .ref_i   (ref_i),
    .dead_i  (dead_i),
    .ref_q_o (ref_q),
    .p_act_o (p_act),
    .n_act_o (n_act)
  );

  cos_break #(.DT_W(DT_W), .SYNC_STAGES(SYNC_STAGES)) u_brk (
    .clk        (clk),
    .rst_n      (rst_n),
    .brk_i      (brk_i),
    .brk2_i     (brk2_i),
    .off_run    (off_run_i),
    .off_idle   (off_idle_i),
    .men_set    (men_set_i),
    .men_clr    (men_clr_i),
    .dead_i     (dead_i),
    .main_en_o  (main_en),
    .idle_lvl_o (idle_lvl),
    .brk_raw_o  (brk_raw)
  );

  cos_outsel u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl     (ctrl),
    .main_en  (main_en),
    .idle_lvl (idle_lvl),
    .ref_q    (ref_q),
    .p_act    (p_act),
    .n_act    (n_act),
    .pin_p    (pin_p),
    .pin_n    (pin_n),
    .run_q    (run_q)
  );

  // Clockless override: active until the registers have taken the idle values.
  assign ovr   = brk_raw & (run_q | main_en);
  assign grant = off_idle_i & (en_p_i | en_n_i);

  assign oe_p_o    = ovr ? grant : pin_p.oe;
  assign out_p_o   = ovr ? (grant & pol_p_i) : pin_p.dat;
  assign oe_n_o    = ovr ? grant : pin_n.oe;
  assign out_n_o   = ovr ? (grant & pol_n_i) : pin_n.dat;
  assign main_en_o = main_en;

endmodule

module cos_outstage_chk (
  input logic clk,
  input logic rst_n,
  input logic ref_i,
  input logic off_idle_i,
  input logic en_p_i,
  input logic en_n_i,
  input logic pol_p_i,
  input logic pol_n_i,
  input logic brk_i,
  input logic brk2_i,
  input logic out_p_o,
  input logic oe_p_o,
  input logic out_n_o,
  input logic oe_n_o,
  input logic main_en_o
);

  p_single_run_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(main_en_o) && $past(en_p_i) && !$past(en_n_i) && !brk_i && !brk2_i)
      |-> (oe_p_o && out_p_o == ($past(ref_i, 2) ^ $past(pol_p_i))));

  p_idle_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(main_en_o) && !main_en_o && !$past(off_idle_i) && !brk_i && !brk2_i)
      |-> (!oe_p_o && !oe_n_o));

  p_async_force_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_i && main_en_o && oe_p_o) |-> (out_p_o == pol_p_i && oe_n_o && out_n_o == pol_n_i));

  // Two synchroniser stages plus the enable register (SYNC_STAGES = 2).
  p_brk_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_i && $past(brk_i) && $past(brk_i, 2) && $past(brk_i, 3)) |-> !main_en_o);

  p_set_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_i && !main_en_o) |=> !main_en_o);

  p_no_overlap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(main_en_o) && !brk_i && !brk2_i)
      |-> !(oe_p_o && oe_n_o && out_p_o != $past(pol_p_i) && out_n_o != $past(pol_n_i)));

endmodule

bind cos_outstage cos_outstage_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ref_i      (ref_i),
  .off_idle_i (off_idle_i),
  .en_p_i     (en_p_i),
  .en_n_i     (en_n_i),
  .pol_p_i    (pol_p_i),
  .pol_n_i    (pol_n_i),
  .brk_i      (brk_i),
  .brk2_i     (brk2_i),
  .out_p_o    (out_p_o),
  .oe_p_o     (oe_p_o),
  .out_n_o    (out_n_o),
  .oe_n_o     (oe_n_o),
  .main_en_o  (main_en_o)
);

// File: tb/tb_cos_outstage.sv
`timescale 1ns/1ps
module tb_cos_outstage;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ref_i;
  logic [7:0] dead_i;
  logic       off_run_i, off_idle_i, en_p_i, en_n_i;
  logic       pol_p_i, pol_n_i, idle_p_i, idle_n_i;
  logic       brk_i, brk2_i, men_set_i, men_clr_i;
  logic       out_p_o, oe_p_o, out_n_o, oe_n_o, main_en_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  cos_outstage dut (
    .clk(clk), .rst_n(rst_n), .ref_i(ref_i), .dead_i(dead_i),
    .off_run_i(off_run_i), .off_idle_i(off_idle_i), .en_p_i(en_p_i), .en_n_i(en_n_i),
    .pol_p_i(pol_p_i), .pol_n_i(pol_n_i), .idle_p_i(idle_p_i), .idle_n_i(idle_n_i),
    .brk_i(brk_i), .brk2_i(brk2_i), .men_set_i(men_set_i), .men_clr_i(men_clr_i),
    .out_p_o(out_p_o), .oe_p_o(oe_p_o), .out_n_o(out_n_o), .oe_n_o(oe_n_o),
    .main_en_o(main_en_o)
  );

  // {men, off_run, off_idle, en_p, en_n, pol_p, pol_n, ref | oe_p, out_p, oe_n, out_n}
  localparam logic [11:0] VEC [12] = '{
    12'b1_0_0_0_0_0_0_1_0000,
    12'b1_1_0_0_0_1_0_1_1110,
    12'b1_0_0_1_0_0_0_1_1100,
    12'b1_1_0_1_0_0_1_1_1111,
    12'b1_0_0_0_1_0_1_1_0010,
    12'b1_1_0_0_1_1_0_0_1110,
    12'b1_0_0_1_1_0_0_1_1110,
    12'b1_0_0_1_1_1_1_0_1110,
    12'b0_0_0_1_1_0_0_1_0000,
    12'b0_0_1_1_0_1_0_1_1110,
    12'b0_1_1_0_1_0_1_0_1011,
    12'b0_1_1_0_0_0_0_1_0000
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_men(input logic v);
    @(negedge clk);
    if (v) men_set_i = 1'b1; else men_clr_i = 1'b1;
    @(negedge clk);
    men_set_i = 1'b0;
    men_clr_i = 1'b0;
  endtask

  function automatic logic [3:0] pins();
    return {oe_p_o, out_p_o, oe_n_o, out_n_o};
  endfunction

  initial begin
    #750000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ref_i = 1'b0; dead_i = 8'd3;
    off_run_i = 0; off_idle_i = 0; en_p_i = 0; en_n_i = 0;
    pol_p_i = 0; pol_n_i = 0; idle_p_i = 0; idle_n_i = 0;
    brk_i = 0; brk2_i = 0; men_set_i = 0; men_clr_i = 0;
    wait_neg(5);
    rst_n = 1'b1;
    wait_neg(2);
    // R11 reset state
    chk("R11 main enable", main_en_o, 0);
    chk("R11 pins", pins(), 4'b0000);

    // Vector table: R1 (main enable set) and R4 (main enable clear)
    foreach (VEC[i]) begin
      @(negedge clk);
      {off_run_i, off_idle_i, en_p_i, en_n_i, pol_p_i, pol_n_i, ref_i} = VEC[i][10:4];
      set_men(VEC[i][11]);
      wait_neg(10);
      chk(VEC[i][11] ? "R1 run table" : "R4 idle table", pins(), VEC[i][3:0]);
    end

    // R9: every control combination with a toggling reference
    dead_i = 8'd2;
    for (int c = 0; c < 128; c++) begin
      int bad = 0;
      @(negedge clk);
      {off_run_i, off_idle_i, en_p_i, en_n_i, pol_p_i, pol_n_i} = c[5:0];
      set_men(c[6]);
      wait_neg(3);
      for (int k = 0; k < 40; k++) begin
        ref_i = ((k * 7) % 5) < 2;
        @(negedge clk);
        if (k > 2 && oe_p_o && oe_n_o && out_p_o != pol_p_i && out_n_o != pol_n_i) bad++;
      end
      chk("R9 overlap", bad[7:0], 0);
    end

    // R2: dead-time on both rising edges, dead_i = 4
    off_run_i = 0; off_idle_i = 0; en_p_i = 1; en_n_i = 1; pol_p_i = 0; pol_n_i = 0;
    dead_i = 8'd4; ref_i = 0;
    set_men(1);
    wait_neg(10);
    begin
      int n = 0;
      logic n_at2 = 1'b1;
      ref_i = 1'b1;
      while (n < 20) begin
        @(negedge clk); n++;
        if (n == 2) n_at2 = out_n_o;
        if (out_p_o) break;
      end
      chk("R2 main rise delay", n[7:0], 8'd6);
      chk("R2 compl falls first", n_at2, 0);
      n = 0;
      ref_i = 1'b0;
      while (n < 20) begin
        @(negedge clk); n++;
        if (out_n_o) break;
      end
      chk("R2 compl rise delay", n[7:0], 8'd6);
    end

    // R3: pulse shorter than dead-time
    dead_i = 8'd6;
    wait_neg(10);
    begin
      logic seen = 1'b0;
      ref_i = 1'b1;
      wait_neg(3);
      ref_i = 1'b0;
      for (int k = 0; k < 15; k++) begin
        @(negedge clk);
        if (out_p_o) seen = 1'b1;
      end
      chk("R3 short pulse", seen, 0);
    end

    // R10: polarity change on next edge
    en_n_i = 0; dead_i = 8'd3; ref_i = 1'b1;
    wait_neg(5);
    pol_p_i = 1'b1;
    #1;
    chk("R10 before edge", out_p_o, 1);
    @(negedge clk);
    chk("R10 after edge", out_p_o, 0);
    pol_p_i = 1'b0;

    // R5, R6, R8: primary break
    en_n_i = 1; off_idle_i = 1; off_run_i = 0; idle_p_i = 0; idle_n_i = 1;
    wait_neg(10);
    chk("R5 pre-break pins", pins(), 4'b1110);
    #1 brk_i = 1'b1;
    #0.5;
    chk("R5 async force", pins(), 4'b1010);
    wait_neg(5);
    chk("R8 break clears enable", main_en_o, 0);
    chk("R6 polarity before step", pins(), 4'b1010);
    wait_neg(15);
    chk("R6 idle levels", pins(), 4'b1011);
    idle_n_i = 1'b0;
    #1;
    chk("R10 idle level before edge", out_n_o, 1);
    @(negedge clk);
    chk("R10 idle level after edge", out_n_o, 0);
    idle_n_i = 1'b1;
    set_men(1);
    chk("R8 set ignored in break", main_en_o, 0);
    brk_i = 1'b0;
    wait_neg(4);
    set_men(1);
    chk("R8 set accepted", main_en_o, 1);
    wait_neg(10);
    chk("R8 run resumes", pins(), 4'b1110);

    // R7: secondary break ignored without both off-state selects
    brk2_i = 1'b1;
    wait_neg(8);
    chk("R7 brk2 ignored enable", main_en_o, 1);
    chk("R7 brk2 ignored pins", pins(), 4'b1110);
    brk2_i = 1'b0;
    off_run_i = 1'b1;
    wait_neg(4);
    #1 brk2_i = 1'b1;
    #0.5;
    chk("R7 brk2 honoured", pins(), 4'b1010);
    wait_neg(20);
    chk("R7 brk2 clears enable", main_en_o, 0);
    chk("R6 no idle step for brk2", pins(), 4'b1010);
    brk2_i = 1'b0;
    wait_neg(4);
    set_men(1);
    chk("R8 set after brk2", main_en_o, 1);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule